// File: doc/BRIEF.md
# Split I/O Request Router with Nibble Indicator Register

This block sits on the data side of a small processor. Every load or store the core issues passes through it. The most significant address bit decides where the request goes. When that bit is clear, the request passes unchanged and in the same cycle to the cache path. When it is set, the request is served locally by a bank of memory-mapped devices. The cache never sees it, and a completion is returned exactly one cycle later.

Inside the device space, one device is picked by an eight-bit one-hot field at address bits [10:3]. The three lowest address bits are the offset within that device. Only slot 0 holds a device: a four-bit indicator register that drives the `led` output. Its only register sits at offset 000, so its absolute address is 0x80000008. The other seven slots read as zero and ignore writes. A select field that is all zero, or that has more than one bit set, hits no device.

Both kinds of completion share one response port toward the core. A pending device completion takes priority on that port. When none is pending, the port carries the cache's response.

Top module: `mmio_split_router`

## Requirements
- R1: With address bit 31 = 0, a valid request appears on the cache request port in the same cycle, with address, write flag, write data and byte strobes unchanged.
- R2: With address bit 31 = 1, the cache request valid stays 0.
- R3: A valid request with address bit 31 = 1 produces `resp_valid` = 1 for exactly the next cycle, whatever the select field holds.
- R4: A write to 0x80000008 with byte strobe bit 0 set loads write data bits [3:0] into the indicator register. `led` shows the new value one cycle later, so a byte value 0x0A gives `led` = 4'b1010 and 0xFF gives 4'b1111.
- R5: A read of 0x80000008 returns the indicator value zero-extended to 32 bits on `resp_rdata` in the response cycle.
- R6: A device access whose select field (bits [10:3]) is zero or has two or more bits set leaves `led` unchanged and returns `resp_rdata` = 0.
- R7: An access to slot 0 at any offset other than 000 leaves `led` unchanged and returns 0.
- R8: After reset `led` = 0 and `resp_valid` = 0.
- R9: When no device completion is pending, `resp_valid` and `resp_rdata` equal `cache_resp_valid` and `cache_resp_rdata` in the same cycle.
- R10: A write to 0x80000008 with byte strobe bit 0 clear leaves `led` unchanged. Every device write completes with `resp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_addr | input | 32 | Core request byte address |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| req_wstrb | input | 4 | Store byte strobes, bit 0 = byte lane 0 |
| cache_req_valid | output | 1 | Request valid toward the cache |
| cache_req_addr | output | 32 | Address toward the cache |
| cache_req_we | output | 1 | Store flag toward the cache |
| cache_req_wdata | output | 32 | Store data toward the cache |
| cache_req_wstrb | output | 4 | Byte strobes toward the cache |
| cache_resp_valid | input | 1 | Completion from the cache |
| cache_resp_rdata | input | 32 | Load data from the cache |
| resp_valid | output | 1 | Completion toward the core |
| resp_rdata | output | 32 | Load data toward the core |
| led | output | 4 | Indicator register value |

## Verification
The assertions assume a blocking core. Such a core has at most one request outstanding, and the cache never completes in the cycle right after a device request, so the two completions never meet on the shared port. The bench follows this rule. Each task issues a single request, waits for that request's completion, and only then starts the next one. Cache responses are driven only while no device access is in flight.

// File: rtl/prt_pkg.sv
package prt_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int STRB_W   = DATA_W / 8;
    localparam int IO_BIT   = ADDR_W - 1;
    localparam int SEL_LSB  = 3;
    localparam int SEL_W    = 8;
    localparam int SUB_W    = 3;
    localparam int LED_W    = 4;
    localparam int LED_SLOT = 0;

    typedef struct packed {
        logic [LED_W-1:0] value;
    } led_state_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
    } resp_state_t;
endpackage

// File: rtl/prt_decode.sv
module prt_decode #(
    parameter int ADDR_W  = prt_pkg::ADDR_W,
    parameter int IO_BIT  = prt_pkg::IO_BIT,
    parameter int SEL_LSB = prt_pkg::SEL_LSB,
    parameter int SEL_W   = prt_pkg::SEL_W,
    parameter int SUB_W   = prt_pkg::SUB_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_io,
    output logic [SEL_W-1:0]  dev_hit,
    output logic [SUB_W-1:0]  sub
);
    localparam int CNT_W = $clog2(SEL_W + 1);

    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] ones;

    assign is_io = addr[IO_BIT];
    assign sel   = addr[SEL_LSB +: SEL_W];
    assign sub   = addr[SUB_W-1:0];

    // count set bits of the select field; only a single set bit picks a device
    always_comb begin
        ones = '0;
        for (int i = 0; i < SEL_W; i++) begin
            ones = ones + CNT_W'(sel[i]);
        end
    end

    assign dev_hit = (ones == CNT_W'(1)) ? sel : '0;
endmodule

// File: rtl/prt_led_reg.sv
module prt_led_reg #(
    parameter int LED_W = prt_pkg::LED_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LED_W-1:0] wr_val,
    output logic [LED_W-1:0] led
);
    prt_pkg::led_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.value = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led = st_q.value;
endmodule

// File: rtl/prt_resp.sv
module prt_resp #(
    parameter int DATA_W = prt_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic              cache_resp_valid,
    input  logic [DATA_W-1:0] cache_resp_rdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata
);
    prt_pkg::resp_state_t st_d, st_q;

    always_comb begin
        st_d.valid = io_req;
        st_d.rdata = io_req ? io_rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a pending device completion owns the shared port
    always_comb begin
        if (st_q.valid) begin
            resp_valid = 1'b1;
            resp_rdata = st_q.rdata;
        end else begin
            resp_valid = cache_resp_valid;
            resp_rdata = cache_resp_rdata;
        end
    end
endmodule

// File: rtl/mmio_split_router.sv
module mmio_split_router #(
    parameter int ADDR_W   = prt_pkg::ADDR_W,
    parameter int DATA_W   = prt_pkg::DATA_W,
    parameter int SEL_LSB  = prt_pkg::SEL_LSB,
    parameter int SEL_W    = prt_pkg::SEL_W,
    parameter int SUB_W    = prt_pkg::SUB_W,
    parameter int LED_W    = prt_pkg::LED_W,
    parameter int LED_SLOT = prt_pkg::LED_SLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_wstrb,
    output logic              cache_req_valid,
    output logic [ADDR_W-1:0] cache_req_addr,
    output logic              cache_req_we,
    output logic [DATA_W-1:0] cache_req_wdata,
    output logic [DATA_W/8-1:0] cache_req_wstrb,
    input  logic              cache_resp_valid,
    input  logic [DATA_W-1:0] cache_resp_rdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [LED_W-1:0]  led
);
    localparam int IO_BIT = ADDR_W - 1;

    logic              is_io;
    logic [SEL_W-1:0]  dev_hit;
    logic [SUB_W-1:0]  sub;
    logic              io_req;
    logic              led_wr;
    logic [DATA_W-1:0] slot_rd [SEL_W];
    logic [DATA_W-1:0] hit_rd;
    logic [DATA_W-1:0] io_rdata;

    prt_decode #(
        .ADDR_W (ADDR_W),
        .IO_BIT (IO_BIT),
        .SEL_LSB(SEL_LSB),
        .SEL_W  (SEL_W),
        .SUB_W  (SUB_W)
    ) u_dec (
        .addr   (req_addr),
        .is_io  (is_io),
        .dev_hit(dev_hit),
        .sub    (sub)
    );

    // cache side: pass through unchanged, valid gated by the split bit
    assign cache_req_valid = req_valid & ~is_io;
    assign cache_req_addr  = req_addr;
    assign cache_req_we    = req_we;
    assign cache_req_wdata = req_wdata;
    assign cache_req_wstrb = req_wstrb;

    assign io_req = req_valid & is_io;
    assign led_wr = io_req & dev_hit[LED_SLOT] & (sub == '0) & req_we & req_wstrb[0];

    prt_led_reg #(
        .LED_W(LED_W)
    ) u_led (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (led_wr),
        .wr_val(req_wdata[LED_W-1:0]),
        .led   (led)
    );

    // per-slot read data; empty slots read as zero
    for (genvar g = 0; g < SEL_W; g++) begin : g_slot
        if (g == LED_SLOT) begin : g_led
            assign slot_rd[g] = (sub == '0) ? DATA_W'(led) : '0;
        end else begin : g_empty
            assign slot_rd[g] = '0;
        end
    end

    always_comb begin
        hit_rd = '0;
        for (int i = 0; i < SEL_W; i++) begin
            hit_rd = hit_rd | (dev_hit[i] ? slot_rd[i] : '0);
        end
    end

    assign io_rdata = req_we ? '0 : hit_rd;

    prt_resp #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk             (clk),
        .rst_n           (rst_n),
        .io_req          (io_req),
        .io_rdata        (io_rdata),
        .cache_resp_valid(cache_resp_valid),
        .cache_resp_rdata(cache_resp_rdata),
        .resp_valid      (resp_valid),
        .resp_rdata      (resp_rdata)
    );
endmodule

// File: rtl/prt_checker.sv
module prt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_we,
    input logic        cache_req_valid,
    input logic [31:0] cache_req_addr,
    input logic        cache_resp_valid,
    input logic        resp_valid,
    input logic [31:0] resp_rdata,
    input logic [3:0]  led
);
    assert_cache_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[31]) |-> (cache_req_valid && cache_req_addr == req_addr));

    assert_cache_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_addr[31] |-> !cache_req_valid);

    assert_io_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31]) |=> resp_valid);

    assert_led_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31] && !req_we && req_addr[10:0] == 11'h008)
        |=> (resp_rdata == {28'b0, $past(led)}));

    assert_bad_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31] && $countones(req_addr[10:3]) != 1) |=> ($stable(led) && resp_rdata == 32'b0));

    assert_led_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_addr[31] && req_we) |=> $stable(led));

    assert_no_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31]) |=> !cache_resp_valid);
endmodule

bind mmio_split_router prt_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_we          (req_we),
    .cache_req_valid (cache_req_valid),
    .cache_req_addr  (cache_req_addr),
    .cache_resp_valid(cache_resp_valid),
    .resp_valid      (resp_valid),
    .resp_rdata      (resp_rdata),
    .led             (led)
);

// File: tb/sim_mmio_split_router.sv
module sim_mmio_split_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_wstrb = '0;
    logic        cache_req_valid;
    logic [31:0] cache_req_addr;
    logic        cache_req_we;
    logic [31:0] cache_req_wdata;
    logic [3:0]  cache_req_wstrb;
    logic        cache_resp_valid = 1'b0;
    logic [31:0] cache_resp_rdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic [3:0]  led;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mmio_split_router u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
        .req_wdata(req_wdata), .req_wstrb(req_wstrb),
        .cache_req_valid(cache_req_valid), .cache_req_addr(cache_req_addr),
        .cache_req_we(cache_req_we), .cache_req_wdata(cache_req_wdata),
        .cache_req_wstrb(cache_req_wstrb),
        .cache_resp_valid(cache_resp_valid), .cache_resp_rdata(cache_resp_rdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .led(led)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one device access: drive at a falling edge, sample the completion one cycle on
    task automatic io_access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                             input logic [3:0] st, input string tag, input logic [31:0] exp_rd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd; req_wstrb = st;
        #1;
        chk(cache_req_valid == 1'b0, {tag, " R2 cache quiet"}, 32'(cache_req_valid), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == 1'b1, {tag, " R3 resp pulse"}, 32'(resp_valid), 32'd1);
        chk(resp_rdata == exp_rd, {tag, " rdata"}, resp_rdata, exp_rd);
        @(negedge clk);
        chk(resp_valid == 1'b0, {tag, " R3 single cycle"}, 32'(resp_valid), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(led == 4'h0, "R8 led reset", 32'(led), 32'd0);
        chk(resp_valid == 1'b0, "R8 resp reset", 32'(resp_valid), 32'd0);
    endtask

    task automatic t_cache_fwd();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_1234; req_we = 1'b1;
        req_wdata = 32'hCAFE_0001; req_wstrb = 4'b1010;
        #1;
        chk(cache_req_valid == 1'b1, "R1 cache valid", 32'(cache_req_valid), 32'd1);
        chk(cache_req_addr == 32'h0000_1234, "R1 cache addr", cache_req_addr, 32'h0000_1234);
        chk(cache_req_wdata == 32'hCAFE_0001 && cache_req_we && cache_req_wstrb == 4'b1010,
            "R1 cache data", cache_req_wdata, 32'hCAFE_0001);
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == 1'b0, "R1 no local completion", 32'(resp_valid), 32'd0);
        chk(led == 4'h0, "R1 led untouched", 32'(led), 32'd0);
    endtask

    task automatic t_cache_resp();
        @(negedge clk);
        cache_resp_valid = 1'b1; cache_resp_rdata = 32'hDEAD_BEEF;
        #1;
        chk(resp_valid == 1'b1, "R9 cache resp valid", 32'(resp_valid), 32'd1);
        chk(resp_rdata == 32'hDEAD_BEEF, "R9 cache resp data", resp_rdata, 32'hDEAD_BEEF);
        @(negedge clk);
        cache_resp_valid = 1'b0;
        #1;
        chk(resp_valid == 1'b0, "R9 cache resp idle", 32'(resp_valid), 32'd0);
    endtask

    task automatic t_led_write_read();
        io_access(32'h8000_0008, 1'b1, 32'h0000_000A, 4'b0001, "R4 write 0A", 32'd0);
        chk(led == 4'b1010, "R4 led 1010", 32'(led), 32'hA);
        io_access(32'h8000_0008, 1'b0, 32'd0, 4'b0000, "R5 read", 32'h0000_000A);
        io_access(32'h8000_0008, 1'b1, 32'h1234_56FF, 4'b0001, "R4 write FF", 32'd0);
        chk(led == 4'hF, "R4 low nibble kept", 32'(led), 32'hF);
        io_access(32'h8000_0008, 1'b0, 32'd0, 4'b0000, "R5 read F", 32'h0000_000F);
    endtask

    task automatic t_bad_select();
        io_access(32'h8000_0000, 1'b1, 32'h3, 4'b0001, "R6 zero select write", 32'd0);
        chk(led == 4'hF, "R6 led kept zero select", 32'(led), 32'hF);
        io_access(32'h8000_0018, 1'b1, 32'h3, 4'b0001, "R6 multi select write", 32'd0);
        chk(led == 4'hF, "R6 led kept multi select", 32'(led), 32'hF);
        io_access(32'h8000_0018, 1'b0, 32'd0, 4'b0000, "R6 multi select read", 32'd0);
        io_access(32'h8000_0010, 1'b0, 32'd0, 4'b0000, "R6 empty slot read", 32'd0);
    endtask

    task automatic t_other_offset();
        io_access(32'h8000_000C, 1'b1, 32'h5, 4'b1111, "R7 offset 4 write", 32'd0);
        chk(led == 4'hF, "R7 led kept", 32'(led), 32'hF);
        io_access(32'h8000_000C, 1'b0, 32'd0, 4'b0000, "R7 offset 4 read", 32'd0);
    endtask

    task automatic t_no_strobe();
        io_access(32'h8000_0008, 1'b1, 32'h6, 4'b0010, "R10 lane0 off", 32'd0);
        chk(led == 4'hF, "R10 led kept", 32'(led), 32'hF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cache_fwd();
        t_cache_resp();
        t_led_write_read();
        t_bad_select();
        t_other_offset();
        t_no_strobe();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule